// File: doc/BRIEF.md
# Pattern Fetch Address Generator

This block sits in a 2D blit engine and produces the video memory byte address of the next pattern byte to fetch during a pattern fill. The pattern is eight rows tall. It may be stored in full colour, with one to four bytes per pixel, or as one bit per pixel for later colour expansion. For a monochrome pattern the block also supplies the index of the bit to test inside the fetched byte. Colour expansion and raster operations happen downstream and are not part of this block.

A blit begins with a `start` pulse. The pulse captures the pattern base, the pixel size, the pattern kind, the memory size mask and the height. While the blit runs, the block keeps a byte counter within the current pattern row and a pattern row counter. It also keeps a remaining-line count. The engine pulses `byte_step` after each destination byte and `line_done` after each destination line. When the remaining-line count wraps below zero, the block raises `done` and ignores the strobes until the next start.

Top module: `pag_addr_gen`

## Requirements
- R1: After reset, `done` is 0, `addr` is 0 and `bit_idx` is 7, and the block is idle.
- R2: A `start` pulse captures size code, mono flag, base, mask and height, clears the row and byte counters, clears `done` and begins a blit, even when a blit is already running.
- R3: With size code 0 (1 byte per pixel) and mono 0, `addr` = ((base & ~7) + row*8 + (cnt & 7)) & mask.
- R4: With size code 1 (2 bytes per pixel) and mono 0, `addr` = ((base & ~15) + row*16 + (cnt & 15)) & mask.
- R5: With size code 2 (3 bytes per pixel) and mono 0, `addr` = ((base & ~31) + row*32 + (cnt mod 24)) & mask.
- R6: With size code 3 (4 bytes per pixel) and mono 0, `addr` = ((base & ~31) + row*32 + (cnt & 31)) & mask.
- R7: With mono 1, `addr` = ((base & ~7) | row) & mask for every size code.
- R8: `bit_idx` = 7 - floor(cnt / bytes_per_pixel), where bytes_per_pixel is the size code plus 1.
- R9: No `addr` bit outside the captured mask is ever 1.
- R10: `byte_step` advances the byte counter by one and wraps it to 0 after 8*bytes_per_pixel - 1. `line_done` clears it to 0, and `line_done` wins when both strobes arrive together.
- R11: Each `line_done` during a blit advances the row by one, and the row wraps from 7 to 0.
- R12: With captured height H, `done` rises on the (H+1)-th `line_done` and stays at 1 until the next `start`.
- R13: While idle (before the first start, or after `done`), `line_done` and `byte_step` change neither `addr`, `bit_idx` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a blit and capture its settings |
| px_size | input | 2 | Bytes per pixel minus one |
| mono | input | 1 | 1: one-bit-per-pixel pattern |
| base | input | ADDR_W | Pattern base byte address |
| vram_mask | input | ADDR_W | Video memory size mask |
| height | input | HGT_W | Lines minus one |
| line_done | input | 1 | End of a destination line |
| byte_step | input | 1 | One destination byte written |
| addr | output | ADDR_W | Pattern byte address to read |
| bit_idx | output | 3 | Bit to test in a monochrome pattern byte |
| done | output | 1 | Blit finished |

## Verification
Random blits mix all four pixel sizes and both pattern kinds. Their bases have random low bits, so that each size's alignment can be told apart from the others. Random masks catch a skipped final mask. Long runs of byte steps reach the 24-byte wrap of the three-byte mode, which separates modulo-24 from the 32-byte mask used by the four-byte mode. Blits of more than eight lines exercise the row wrap. Directed cases cover a restart in the middle of a blit, strobes while idle, and a strobe collision, where `line_done` must win over `byte_step`.

// File: rtl/pag_pkg.sv
package pag_pkg;

    // Pixel size code: bytes per pixel minus one
    typedef enum logic [1:0] {
        PX_1B = 2'd0,
        PX_2B = 2'd1,
        PX_3B = 2'd2,
        PX_4B = 2'd3
    } px_size_e;

    localparam int PAT_ROWS = 8;
    localparam int ROW_W    = $clog2(PAT_ROWS);
    localparam int CNT_W    = 5;             // byte counter reaches 31

    function automatic int px_bytes(input int code);
        return code + 1;
    endfunction

    // bytes in one pattern row for a given size code
    function automatic int row_span(input int code);
        return PAT_ROWS * px_bytes(code);
    endfunction

    // number of low base bits cleared, equal to log2 of the row stride
    function automatic int align_bits(input int code);
        case (code)
            0:       return 3;
            1:       return 4;
            default: return 5;
        endcase
    endfunction

    // byte offset inside the row, per size code
    function automatic logic [CNT_W-1:0] row_wrap(input int code, input logic [CNT_W-1:0] c);
        case (code)
            0:       return c & 5'd7;
            1:       return c & 5'd15;
            2:       return (c >= 5'd24) ? c - 5'd24 : c;
            default: return c;
        endcase
    endfunction

    // floor(c / 3) for c below 32
    function automatic logic [CNT_W-1:0] div3(input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] q;
        q = '0;
        for (int k = 1; k <= 10; k++) begin
            if (c >= CNT_W'(3 * k)) q = CNT_W'(k);
        end
        return q;
    endfunction

endpackage

// File: rtl/pag_seq.sv
module pag_seq
    import pag_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int HGT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        px_in,
    input  logic              mono_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] mask_in,
    input  logic [HGT_W-1:0]  hgt_in,
    input  logic              line_done,
    input  logic              byte_step,
    output px_size_e          px_q,
    output logic              mono_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] mask_q,
    output logic [ROW_W-1:0]  row_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [HGT_W-1:0]  hgt_q,
    output logic              busy_q,
    output logic              done_q
);

    typedef struct packed {
        px_size_e          px;
        logic              mono;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [ROW_W-1:0]  row;
        logic [CNT_W-1:0]  cnt;
        logic [HGT_W-1:0]  hgt;
        logic              busy;
        logic              done;
    } seq_t;

    seq_t st_d, st_q;
    logic [CNT_W-1:0] cnt_last;

    // last byte index of a pattern row for the running size
    always_comb begin
        case (st_q.px)
            PX_1B:   cnt_last = CNT_W'(row_span(0) - 1);
            PX_2B:   cnt_last = CNT_W'(row_span(1) - 1);
            PX_3B:   cnt_last = CNT_W'(row_span(2) - 1);
            default: cnt_last = CNT_W'(row_span(3) - 1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.px   = px_size_e'(px_in);
            st_d.mono = mono_in;
            st_d.base = base_in;
            st_d.mask = mask_in;
            st_d.hgt  = hgt_in;
            st_d.row  = '0;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
        end else if (st_q.busy) begin
            if (line_done) begin
                st_d.row = st_q.row + 1'b1;
                st_d.cnt = '0;
                st_d.hgt = st_q.hgt - 1'b1;
                if (st_q.hgt == '0) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end else if (byte_step) begin
                st_d.cnt = (st_q.cnt == cnt_last) ? '0 : st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{px: PX_1B, mono: 1'b0, base: '0, mask: '0, row: '0,
                      cnt: '0, hgt: '0, busy: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign px_q   = st_q.px;
    assign mono_q = st_q.mono;
    assign base_q = st_q.base;
    assign mask_q = st_q.mask;
    assign row_q  = st_q.row;
    assign cnt_q  = st_q.cnt;
    assign hgt_q  = st_q.hgt;
    assign busy_q = st_q.busy;
    assign done_q = st_q.done;

endmodule

// File: rtl/pag_addr.sv
module pag_addr
    import pag_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  px_size_e          px,
    input  logic              mono,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ROW_W-1:0]  row,
    input  logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] addr
);

    localparam int N_SIZES = 4;

    logic [ADDR_W-1:0] full_cand [N_SIZES];
    logic [ADDR_W-1:0] mono_addr;
    logic [ADDR_W-1:0] raw_addr;

    // one full-colour candidate per pixel size
    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int AB = align_bits(g);
        logic [ADDR_W-1:0] aligned;
        logic [ADDR_W-1:0] row_off;
        logic [ADDR_W-1:0] col_off;
        always_comb begin
            aligned = base & ~ADDR_W'((1 << AB) - 1);
            row_off = ADDR_W'(row) << AB;
            col_off = ADDR_W'(row_wrap(g, cnt));
            full_cand[g] = aligned + row_off + col_off;
        end
    end

    always_comb begin
        mono_addr = (base & ~ADDR_W'(7)) | ADDR_W'(row);
        raw_addr  = mono ? mono_addr : full_cand[px];
        addr      = raw_addr & mask;
    end

endmodule

// File: rtl/pag_bitsel.sv
module pag_bitsel
    import pag_pkg::*;
(
    input  px_size_e         px,
    input  logic [CNT_W-1:0] cnt,
    output logic [2:0]       bit_idx
);

    logic [CNT_W-1:0] pix_no;

    always_comb begin
        case (px)
            PX_1B:   pix_no = cnt;
            PX_2B:   pix_no = cnt >> 1;
            PX_3B:   pix_no = div3(cnt);
            default: pix_no = cnt >> 2;
        endcase
        bit_idx = 3'd7 - pix_no[2:0];
    end

endmodule

// File: rtl/pag_addr_gen.sv
module pag_addr_gen
    import pag_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int HGT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        px_size,
    input  logic              mono,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] vram_mask,
    input  logic [HGT_W-1:0]  height,
    input  logic              line_done,
    input  logic              byte_step,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        bit_idx,
    output logic              done
);

    px_size_e          px_q;
    logic              mono_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ROW_W-1:0]  row_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HGT_W-1:0]  hgt_q;
    logic              busy_q;
    logic              done_q;

    pag_seq #(.ADDR_W(ADDR_W), .HGT_W(HGT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .px_in     (px_size),
        .mono_in   (mono),
        .base_in   (base),
        .mask_in   (vram_mask),
        .hgt_in    (height),
        .line_done (line_done),
        .byte_step (byte_step),
        .px_q      (px_q),
        .mono_q    (mono_q),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .row_q     (row_q),
        .cnt_q     (cnt_q),
        .hgt_q     (hgt_q),
        .busy_q    (busy_q),
        .done_q    (done_q)
    );

    pag_addr #(.ADDR_W(ADDR_W)) u_addr (
        .px   (px_q),
        .mono (mono_q),
        .base (base_q),
        .mask (mask_q),
        .row  (row_q),
        .cnt  (cnt_q),
        .addr (addr)
    );

    pag_bitsel u_bit (
        .px      (px_q),
        .cnt     (cnt_q),
        .bit_idx (bit_idx)
    );

    assign done = done_q;

endmodule

// File: rtl/pag_chk.sv
module pag_chk
    import pag_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int HGT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              line_done,
    input logic              byte_step,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] mask_q,
    input px_size_e          px_q,
    input logic [ROW_W-1:0]  row_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [HGT_W-1:0]  hgt_q,
    input logic              busy_q,
    input logic              done
);

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (row_q == '0 && cnt_q == '0 && !done && busy_q));

    p_addr_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr & ~mask_q) == '0);

    p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < row_span(int'(px_q)));

    p_line_clears_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && busy_q && line_done) |=> cnt_q == '0);

    p_row_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && busy_q && line_done) |=> row_q == ROW_W'($past(row_q) + 1'b1));

    p_done_on_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && busy_q && line_done && hgt_q == '0) |=> (done && !busy_q));

    p_done_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_idle_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> ($stable(row_q) && $stable(cnt_q) && $stable(addr)));

endmodule

bind pag_addr_gen pag_chk #(.ADDR_W(ADDR_W), .HGT_W(HGT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .line_done (line_done),
    .byte_step (byte_step),
    .addr      (addr),
    .mask_q    (mask_q),
    .px_q      (px_q),
    .row_q     (row_q),
    .cnt_q     (cnt_q),
    .hgt_q     (hgt_q),
    .busy_q    (busy_q),
    .done      (done)
);

// File: tb/tb_pag_addr_gen.sv
module tb_pag_addr_gen;

    localparam int AW = 22;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    px_size = 2'd0;
    logic          mono = 1'b0;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] vram_mask = '0;
    logic [HW-1:0] height = '0;
    logic          line_done = 1'b0;
    logic          byte_step = 1'b0;
    logic [AW-1:0] addr;
    logic [2:0]    bit_idx;
    logic          done;

    pag_addr_gen #(.ADDR_W(AW), .HGT_W(HW)) dut (.*);

    always #5 clk = ~clk;   // 100 MHz

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    int  m_px, m_row, m_cnt, m_hgt;
    bit  m_mono, m_busy, m_done;
    longint m_base, m_mask;

    function automatic longint ref_addr();
        longint a;
        if (m_mono) a = (m_base & ~longint'(7)) | m_row;
        else case (m_px)
            0: a = (m_base & ~longint'(7))  + m_row * 8  + (m_cnt & 7);
            1: a = (m_base & ~longint'(15)) + m_row * 16 + (m_cnt & 15);
            2: a = (m_base & ~longint'(31)) + m_row * 32 + (m_cnt % 24);
            default: a = (m_base & ~longint'(31)) + m_row * 32 + (m_cnt & 31);
        endcase
        return a & m_mask & ((longint'(1) << AW) - 1);
    endfunction

    function automatic int ref_bit();
        return 7 - m_cnt / (m_px + 1);
    endfunction

    function automatic string addr_tag();
        if (m_mono) return "R7";
        case (m_px)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, "/", addr_tag(), " addr"}, longint'(addr), ref_addr());
        check({tag, "/R8 bit_idx"}, longint'(bit_idx), longint'(ref_bit()));
        check({tag, "/R12 done"}, longint'(done), longint'(m_done));
        if ((addr & ~vram_mask_q_model()) != '0)
            check("R9 mask", longint'(addr), ref_addr());
    endtask

    function automatic logic [AW-1:0] vram_mask_q_model();
        return AW'(m_mask);
    endfunction

    task automatic cyc(input bit s, input bit ld, input bit bs, input string tag);
        @(negedge clk);
        start = s; line_done = ld; byte_step = bs;
        @(posedge clk);
        if (s) begin
            m_px = int'(px_size); m_mono = mono; m_base = longint'(base);
            m_mask = longint'(vram_mask); m_hgt = int'(height);
            m_row = 0; m_cnt = 0; m_busy = 1; m_done = 0;
        end else if (m_busy) begin
            if (ld) begin
                m_row = (m_row + 1) % 8;
                m_cnt = 0;
                if (m_hgt == 0) begin m_busy = 0; m_done = 1; end
                m_hgt = (m_hgt - 1) & 16'hFFFF;
            end else if (bs) begin
                m_cnt = (m_cnt + 1 == 8 * (m_px + 1)) ? 0 : m_cnt + 1;
            end
        end
        #2;
        check_all(tag);
        @(negedge clk);
        start = 0; line_done = 0; byte_step = 0;
    endtask

    task automatic setup(input int px, input bit mo, input int b, input int msk, input int h);
        px_size = 2'(px); mono = mo; base = AW'(b); vram_mask = AW'(msk); height = HW'(h);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        s = $urandom(32'd2718);
        m_px = 0; m_row = 0; m_cnt = 0; m_hgt = 0;
        m_mono = 0; m_busy = 0; m_done = 0; m_base = 0; m_mask = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 addr", longint'(addr), 0);
        check("R1 bit_idx", longint'(bit_idx), 7);
        check("R1 done", longint'(done), 0);
        @(negedge clk); rst_n = 1'b1;

        // R13 strobes before any start have no effect
        cyc(0, 1, 0, "R13 idle ld");
        cyc(0, 0, 1, "R13 idle bs");

        // R5 three-byte wrap at 24 inside a 32 stride
        setup(2, 0, 32'h1234F, 32'h3FFFFF, 3);
        cyc(1, 0, 0, "R2 start");
        for (int i = 0; i < 30; i++) cyc(0, 0, 1, "R10 R5 step");
        // R10 collision: line_done wins
        cyc(0, 1, 1, "R10 collide");

        // R11 row wrap across more than 8 lines, 4-byte pixels, narrow mask R9
        setup(3, 0, 32'h2ABCD, 32'h003FF, 11);
        cyc(1, 0, 0, "R2 start");
        for (int l = 0; l < 12; l++) begin
            for (int i = 0; i < 3; i++) cyc(0, 0, 1, "R6 R9 step");
            cyc(0, 1, 0, "R11 R12 line");
        end
        // R12 done holds; R13 strobes after done ignored
        cyc(0, 1, 0, "R13 after done");
        cyc(0, 0, 1, "R13 after done");

        // R2 restart mid-blit (mono, 2-byte)
        setup(1, 1, 32'h00F0D, 32'h3FFFFF, 40);
        cyc(1, 0, 0, "R2 start");
        cyc(0, 1, 0, "R7 line");
        cyc(0, 0, 1, "R8 step");
        setup(0, 0, 32'h00777, 32'h3FFFFF, 2);
        cyc(1, 0, 0, "R2 restart");

        // random blits
        for (int b = 0; b < 60; b++) begin
            setup($urandom_range(0, 3), 1'($urandom_range(0, 1)), $urandom,
                  ($urandom_range(0, 3) == 0) ? $urandom : 32'h3FFFFF,
                  $urandom_range(0, 12));
            cyc(1, 0, 0, "R2 start");
            while (m_busy) begin
                int r;
                r = $urandom_range(0, 9);
                cyc(0, r == 0, r > 2, "rand");
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule